// File: doc/BRIEF.md
# Host Port Data Handshake

This block sits between an external host and a processor core and moves data words from the host into a small bank of data registers. The host drives asynchronous write and read strobes with an address and data word, and waits for an acknowledge. The core reads the data registers, reads a status register and writes one control bit in it, and receives one interrupt line per data register. All host-side logic keeps running while the core is in powerdown. Host writes made during that time are stored, and their interrupts are held pending.

The status register controls how the acknowledge behaves. When the overwrite bit is set, a host write is acknowledged as soon as it is stored, and a later write replaces data the core has not yet read. When the overwrite bit is clear, the acknowledge for a write is held until the core reads that register. During powerdown the core cannot read, so the host stays stalled for as long as the core sleeps.

When the core leaves powerdown, a wake-mode input chooses between two outcomes. In the keep-context mode, pending host interrupts are delivered. In the context-reset mode, all pending interrupts and data-valid flags are discarded, and a held acknowledge is released.

Top module: `hostport_handshake`

## Requirements
- R1: After reset, `host_ack` is 0, `core_irq` is all zeros and `core_stat` is 0x00, so overwrite is disabled.
- R2: Each host strobe passes through a two-stage synchronizer. A write takes effect on the third rising clock edge after the strobe goes high, and no acknowledge is visible after only two edges.
- R3: Host writes are accepted while `core_pd` is high. The data is stored and the register's valid flag (`core_stat` bit equal to the register index) is set.
- R4: `core_irq[i]` goes high on the same edge that a host write to register i is stored, provided the core is not in powerdown. It is forced low while `core_pd` is high, and it is cleared by a core read of register i.
- R5: With the overwrite bit set, `host_ack` rises on the edge that stores the write. A second write replaces unread data.
- R6: With the overwrite bit clear, `host_ack` stays low after a write until the core reads that register. It rises on the edge that performs the read.
- R7: With the overwrite bit clear and `core_pd` high, `host_ack` stays low for as long as powerdown lasts, including when the core attempts a read.
- R8: When `core_pd` falls while `wake_keep` is 1, a pending interrupt appears on `core_irq` on that edge, and the stored data stays readable.
- R9: When `core_pd` falls while `wake_keep` is 0, all valid flags and pending interrupts are cleared on that edge, and a held acknowledge is raised.
- R10: `core_stat` bit 7 is the overwrite enable and is written from `core_stat_wdata[7]`. Bits [N_REG-1:0] are the valid flags, and all other bits read 0. Core status writes and core data reads are ignored while `core_pd` is high.
- R11: After the host drops its strobe, `host_ack` falls on the third rising edge.
- R12: A host read strobe returns the addressed register on `host_rdata`, together with `host_ack`, on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, asynchronous, active high |
| host_rd | input | 1 | Host read strobe, asynchronous, active high |
| host_addr | input | ADDR_W | Host register index, stable while a strobe is high |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| host_ack | output | 1 | Host acknowledge |
| core_pd | input | 1 | Core is in powerdown |
| wake_keep | input | 1 | Wake mode sampled when core_pd falls: 1 keeps pending interrupts, 0 clears them |
| core_rd | input | 1 | Core data register read enable |
| core_addr | input | ADDR_W | Core read register index |
| core_rdata | output | DATA_W | Core read data, registered |
| core_stat_we | input | 1 | Core status register write enable |
| core_stat_wdata | input | 8 | Core status write data (bit 7 is used) |
| core_stat | output | 8 | Status: bit 7 overwrite enable, low bits valid flags |
| core_irq | output | N_REG | Host-write interrupt, one per register |

## Verification
Host writes are made with overwrite enabled and with it disabled. This separates the immediate acknowledge from the acknowledge held until a core read. A repeated write without an intervening read shows whether data is replaced. The same held write is then issued while the core is in powerdown and the core is woken in each mode. This separates delivery of the pending interrupt from the clearing of pending state and the release of the acknowledge. Core reads and status writes issued during powerdown confirm that they change nothing. Samples taken two and three edges after a strobe changes pin down the synchronizer latency in both directions.

// File: rtl/hph_pkg.sv
package hph_pkg;
  localparam int STAT_W  = 8;
  localparam int OVR_BIT = 7;
endpackage

// File: rtl/hph_sync.sv
module hph_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], async_in};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = level & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rise |=> !rise); // R2
endmodule

// File: rtl/hph_regfile.sv
module hph_regfile #(
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  parameter int ADDR_W = $clog2(N_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hre,
  input  logic [ADDR_W-1:0] haddr,
  output logic [DATA_W-1:0] hrdata,
  input  logic              cre,
  input  logic [ADDR_W-1:0] caddr,
  output logic [DATA_W-1:0] crdata
);
  logic [DATA_W-1:0] mem [N_REG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hrdata <= '0;
      crdata <= '0;
    end else begin
      if (hre) hrdata <= mem[haddr];
      if (cre) crdata <= mem[caddr];
    end
  end

  AST_CORE_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !cre |=> $stable(crdata)); // R10
endmodule

// File: rtl/hph_ctrl.sv
module hph_ctrl
  import hph_pkg::*;
#(
  parameter int N_REG  = 4,
  parameter int ADDR_W = $clog2(N_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic              strobe_act,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              core_pd,
  input  logic              wake_keep,
  input  logic              core_rd,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              stat_we,
  input  logic              stat_ovr_in,
  output logic              core_rd_ok,
  output logic              ack,
  output logic [N_REG-1:0]  irq,
  output logic [STAT_W-1:0] stat
);
  logic [N_REG-1:0]  valid_q, valid_nx;
  logic [N_REG-1:0]  pend_q, pend_nx;
  logic              wait_q, wait_nx;
  logic [ADDR_W-1:0] wait_addr_q;
  logic              ovr_q, pd_q;
  logic              ctx_clr, release_ack, grant;

  assign core_rd_ok  = core_rd & ~core_pd;
  assign ctx_clr     = pd_q & ~core_pd & ~wake_keep;
  assign release_ack = wait_q & ((core_rd_ok & (core_addr == wait_addr_q)) | ctx_clr);
  assign grant       = (wr_evt & ovr_q) | rd_evt | release_ack;

  always_comb begin
    valid_nx = valid_q;
    pend_nx  = pend_q;
    if (ctx_clr) begin
      valid_nx = '0;
      pend_nx  = '0;
    end
    if (core_rd_ok) begin
      valid_nx[core_addr] = 1'b0;
      pend_nx[core_addr]  = 1'b0;
    end
    if (wr_evt) begin
      valid_nx[host_addr] = 1'b1;
      pend_nx[host_addr]  = 1'b1;
    end
    if (wr_evt && !ovr_q)           wait_nx = 1'b1;
    else if (release_ack || !strobe_act) wait_nx = 1'b0;
    else                            wait_nx = wait_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      pend_q      <= '0;
      wait_q      <= 1'b0;
      wait_addr_q <= '0;
      ovr_q       <= 1'b0;
      pd_q        <= 1'b0;
      ack         <= 1'b0;
      irq         <= '0;
    end else begin
      valid_q <= valid_nx;
      pend_q  <= pend_nx;
      wait_q  <= wait_nx;
      if (wr_evt) wait_addr_q <= host_addr;
      if (stat_we && !core_pd) ovr_q <= stat_ovr_in;
      pd_q    <= core_pd;
      ack     <= strobe_act & (ack | grant);
      irq     <= pend_nx & {N_REG{~core_pd}};
    end
  end

  always_comb begin
    stat             = '0;
    stat[OVR_BIT]    = ovr_q;
    stat[N_REG-1:0]  = valid_q;
  end

  AST_PD_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !ack && core_pd && !rd_evt) |=> !ack); // R7
  AST_PD_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    core_pd |=> (irq == '0)); // R4
  AST_CTX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctx_clr && !wr_evt) |=> (valid_q == '0 && pend_q == '0)); // R9
  AST_VALID_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> valid_q[$past(host_addr)]); // R3
endmodule

// File: rtl/hostport_handshake.sv
module hostport_handshake
  import hph_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int N_REG       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(N_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack,
  input  logic              core_pd,
  input  logic              wake_keep,
  input  logic              core_rd,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              core_stat_we,
  input  logic [STAT_W-1:0] core_stat_wdata,
  output logic [STAT_W-1:0] core_stat,
  output logic [N_REG-1:0]  core_irq
);
  localparam int N_STROBE = 2;

  logic [N_STROBE-1:0] strobe_raw, strobe_lvl, strobe_rise;
  logic                core_rd_ok;

  assign strobe_raw = {host_rd, host_wr};

  for (genvar s = 0; s < N_STROBE; s++) begin : g_sync
    hph_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (strobe_raw[s]),
      .level    (strobe_lvl[s]),
      .rise     (strobe_rise[s])
    );
  end

  hph_regfile #(.DATA_W(DATA_W), .N_REG(N_REG), .ADDR_W(ADDR_W)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (strobe_rise[0]),
    .waddr  (host_addr),
    .wdata  (host_wdata),
    .hre    (strobe_rise[1]),
    .haddr  (host_addr),
    .hrdata (host_rdata),
    .cre    (core_rd_ok),
    .caddr  (core_addr),
    .crdata (core_rdata)
  );

  hph_ctrl #(.N_REG(N_REG), .ADDR_W(ADDR_W)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_evt      (strobe_rise[0]),
    .rd_evt      (strobe_rise[1]),
    .strobe_act  (|strobe_lvl),
    .host_addr   (host_addr),
    .core_pd     (core_pd),
    .wake_keep   (wake_keep),
    .core_rd     (core_rd),
    .core_addr   (core_addr),
    .stat_we     (core_stat_we),
    .stat_ovr_in (core_stat_wdata[OVR_BIT]),
    .core_rd_ok  (core_rd_ok),
    .ack         (host_ack),
    .irq         (core_irq),
    .stat        (core_stat)
  );
endmodule

// File: tb/test_hostport_handshake.sv
module test_hostport_handshake;
  localparam int DATA_W = 16;
  localparam int N_REG  = 4;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              host_wr, host_rd;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic [DATA_W-1:0] host_rdata;
  logic              host_ack;
  logic              core_pd, wake_keep, core_rd;
  logic [ADDR_W-1:0] core_addr;
  logic [DATA_W-1:0] core_rdata;
  logic              core_stat_we;
  logic [7:0]        core_stat_wdata;
  logic [7:0]        core_stat;
  logic [N_REG-1:0]  core_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hostport_handshake #(.DATA_W(DATA_W), .N_REG(N_REG)) i_hostport_handshake (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .core_pd(core_pd), .wake_keep(wake_keep),
    .core_rd(core_rd), .core_addr(core_addr), .core_rdata(core_rdata),
    .core_stat_we(core_stat_we), .core_stat_wdata(core_stat_wdata),
    .core_stat(core_stat), .core_irq(core_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write_go(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
  endtask

  task automatic host_release();
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    edges(2);
    chk("R11 ack held two edges after drop", host_ack, 1'b1);
    edges(1);
    chk("R11 ack low after drop", host_ack, 1'b0);
  endtask

  task automatic core_read(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    core_rd = 1'b1; core_addr = a;
    @(posedge clk);
    @(negedge clk);
    core_rd = 1'b0;
  endtask

  task automatic stat_write(input logic [7:0] v);
    @(negedge clk);
    core_stat_we = 1'b1; core_stat_wdata = v;
    @(posedge clk);
    @(negedge clk);
    core_stat_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ack after reset", host_ack, 1'b0);
    chk("R1 irq after reset", core_irq, 4'b0000);
    chk("R1 status after reset", core_stat, 8'h00);
  endtask

  task automatic t_overwrite();
    stat_write(8'h80);
    chk("R10 overwrite bit written", core_stat, 8'h80);
    host_write_go(2'd1, 16'hA5A5);
    edges(2);
    chk("R2 no ack after two edges", host_ack, 1'b0);
    edges(1);
    chk("R5 ack on third edge", host_ack, 1'b1);
    chk("R4 irq on store", core_irq, 4'b0010);
    chk("R10 valid flag in status", core_stat, 8'h82);
    host_release();
    host_write_go(2'd1, 16'h1234);
    edges(3);
    chk("R5 second write acked", host_ack, 1'b1);
    host_release();
    core_read(2'd1);
    chk("R5 unread data replaced", core_rdata, 16'h1234);
    chk("R4 irq cleared by read", core_irq, 4'b0000);
    chk("R10 valid cleared by read", core_stat, 8'h80);
  endtask

  task automatic t_hold();
    stat_write(8'h00);
    host_write_go(2'd2, 16'hBEEF);
    edges(8);
    chk("R6 ack withheld before read", host_ack, 1'b0);
    chk("R4 irq raised", core_irq, 4'b0100);
    core_read(2'd2);
    chk("R6 ack after core read", host_ack, 1'b1);
    chk("R6 read data", core_rdata, 16'hBEEF);
    host_release();
  endtask

  task automatic t_pd_keep();
    logic [DATA_W-1:0] prev;
    @(negedge clk);
    core_pd = 1'b1;
    host_write_go(2'd0, 16'h0F0F);
    edges(40);
    chk("R7 ack low in powerdown", host_ack, 1'b0);
    chk("R4 irq masked in powerdown", core_irq, 4'b0000);
    chk("R3 write stored in powerdown", core_stat, 8'h01);
    prev = core_rdata;
    core_read(2'd0);
    chk("R10 core read ignored in powerdown", core_rdata, prev);
    chk("R7 ack low after read attempt", host_ack, 1'b0);
    stat_write(8'h80);
    chk("R10 status write ignored in powerdown", core_stat, 8'h01);
    @(negedge clk);
    core_pd = 1'b0; wake_keep = 1'b1;
    edges(1);
    chk("R8 pending irq delivered", core_irq, 4'b0001);
    chk("R6 ack still held after wake", host_ack, 1'b0);
    core_read(2'd0);
    chk("R8 ack after read", host_ack, 1'b1);
    chk("R8 data kept", core_rdata, 16'h0F0F);
    host_release();
  endtask

  task automatic t_pd_ctx();
    @(negedge clk);
    core_pd = 1'b1;
    host_write_go(2'd3, 16'h7777);
    edges(10);
    chk("R7 ack low in powerdown", host_ack, 1'b0);
    @(negedge clk);
    core_pd = 1'b0; wake_keep = 1'b0;
    edges(1);
    chk("R9 ack released", host_ack, 1'b1);
    chk("R9 irq cleared", core_irq, 4'b0000);
    chk("R9 valid cleared", core_stat, 8'h00);
    host_release();
  endtask

  task automatic t_host_read();
    @(negedge clk);
    host_addr = 2'd0; host_rd = 1'b1;
    edges(2);
    chk("R12 no ack after two edges", host_ack, 1'b0);
    edges(1);
    chk("R12 read ack", host_ack, 1'b1);
    chk("R12 read data", host_rdata, 16'h0F0F);
    host_release();
  endtask

  initial begin
    rst = 1'b1; host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
    core_pd = 0; wake_keep = 1; core_rd = 0; core_addr = '0;
    core_stat_we = 0; core_stat_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    edges(1);
    t_reset();
    t_overwrite();
    t_hold();
    t_pd_keep();
    t_pd_ctx();
    t_host_read();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule